// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block turns one command into a complete I2C transaction for register-style devices and small EEPROMs. It sits above an external bit/byte engine that knows how to produce a START, a STOP, one written byte with its acknowledge, or one read byte with a chosen acknowledge level. The sequencer decides which of those primitives to issue, in which order, and with which byte. It also gathers the acknowledge results into a status.

A command is a probe, a read or a write. It carries a 7-bit device address, an internal address of 0 to `ABYTES` bytes, and a data length. Write payload is pulled from a byte stream. Read payload is pushed out as one-cycle strobes. Two configuration inputs shape the framing. The first chooses how the address phase of a read is separated from its data phase. The second is a mask: for parts that hide high memory-address bits in the device address, it folds the internal-address bits above the programmed length into that address.

Top module: `i2c_xact_seq`

## Requirements
- R1: A probe (`cmd_op`=0) issues START, then a write of `{chip,0}`, then STOP. `st_present` is 1 only when that byte was acknowledged (`eng_nack_in`=0).
- R2: For a read (`cmd_op`=1) with `cmd_alen`>0, and for every write (`cmd_op`=2), the first byte is `{chip,0}`. If it is not acknowledged, the block issues STOP, sets `st_nochip` and sends nothing else.
- R3: The internal-address bytes follow the device byte, most significant byte first. Byte k (counted from 0 at the least significant end) is `cmd_addr[8k+7:8k]`.
- R4: A NACK on any internal-address byte sets `st_addr_err` and ends the command at once, with no STOP.
- R5: After the address phase of a read, `cfg_rep_start`=0 gives STOP then START, and `cfg_rep_start`=1 gives START alone.
- R6: A read with `cmd_alen`=0 skips the address phase: START is followed directly by `{chip,1}`.
- R7: The read phase writes `{chip,1}` and ignores its acknowledge. It then issues `cmd_len` reads, with `eng_nack_out`=0 on each and 1 on the last, and ends with STOP. Each byte appears on `rd_data` with a one-cycle `rd_valid`.
- R8: For a read or write, the device address used is `chip | ((addr >> 8*alen) & mask)`, with `cfg_fold_mask` as the mask. A probe uses `chip` unchanged.
- R9: A write sends `cmd_len` bytes taken in order from the `wr_data`/`wr_valid`/`wr_ready` stream. Each NACK is counted into `st_fail_cnt` without stopping, and the write ends with STOP.
- R10: `cmd_len`=0 still yields a complete transaction that ends in STOP.
- R11: Status outputs are cleared when a command is accepted, and hold their value from `done` until the next command. `done` is a one-cycle pulse, after which `busy` is low.
- R12: `eng_req` is a one-cycle pulse, issued only while `busy`. At most one primitive is outstanding until `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a command; taken when `busy` is low |
| cmd_op | input | 2 | 0 probe, 1 read, 2 write |
| cmd_chip | input | 7 | Device address |
| cmd_addr | input | 8*ABYTES | Internal address |
| cmd_alen | input | clog2(ABYTES+1) | Internal address length in bytes (0..ABYTES) |
| cmd_len | input | LEN_W | Data length in bytes |
| cfg_rep_start | input | 1 | 1: repeated START before read phase; 0: STOP then START |
| cfg_fold_mask | input | 7 | Mask of high address bits folded into the device address |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Write payload byte taken this cycle when valid |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| eng_req | output | 1 | Primitive request pulse to the byte engine |
| eng_op | output | 2 | Primitive: 0 START, 1 STOP, 2 write byte, 3 read byte |
| eng_wdata | output | 8 | Byte to write |
| eng_nack_out | output | 1 | Acknowledge level to drive after a read byte (1 = NACK) |
| eng_done | input | 1 | Primitive finished |
| eng_nack_in | input | 1 | Written byte was not acknowledged (valid with `eng_done`) |
| eng_rdata | input | 8 | Byte read (valid with `eng_done`) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| st_present | output | 1 | Probe result |
| st_nochip | output | 1 | Device byte not acknowledged |
| st_addr_err | output | 1 | Internal address byte not acknowledged |
| st_fail_cnt | output | LEN_W | Number of NACKed write data bytes |

## Verification
The engine model acknowledges or refuses each written byte according to a per-command pattern. This lets the same command shape be tried with every byte acknowledged, with the device byte refused, with one internal-address byte refused, and with some or all payload bytes refused. Comparing the primitive sequence shows whether the block aborts with STOP, aborts silently, or carries on counting. Reads are run with both settings of the mid-phase selection and with address lengths of 0, 1 and 2, which separates repeated-START framing from STOP/START and from skipped addressing. Folding is checked with address values whose bits above the programmed length are non-zero, so that a wrong shift or mask changes the device byte.

// File: rtl/i2c_xact_pkg.sv
// Shared encodings for the I2C transaction sequencer.
// Assumes: the byte engine decodes eng_op with the values below.
package i2c_xact_pkg;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_READ  = 2'd3
    } eng_op_e;

    localparam logic [1:0] OP_PROBE = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DEVW,
        S_ADDR,
        S_MSTOP,
        S_MSTART,
        S_DEVR,
        S_RDATA,
        S_WDATA,
        S_STOP,
        S_FIN
    } seq_state_e;

endpackage

// File: rtl/i2c_xact_addr.sv
// Address byte builder: forms the write/read device bytes (with optional
// folding of high internal-address bits) and selects the internal address
// byte indexed by the remaining-byte counter.
// Assumes: alen <= ABYTES and aidx in 1..alen while the address is sent.
module i2c_xact_addr #(
    parameter int ABYTES = 4,
    localparam int AW     = $clog2(ABYTES + 1),
    localparam int ADDR_W = 8 * ABYTES
) (
    input  logic [6:0]        chip,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AW-1:0]     alen,
    input  logic [AW-1:0]     aidx,
    input  logic [6:0]        mask,
    input  logic              fold_en,
    output logic [7:0]        dev_wr,
    output logic [7:0]        dev_rd,
    output logic [7:0]        addr_byte
);

    logic [ADDR_W-1:0] hi_bits;
    logic [ADDR_W-1:0] sel_bits;
    logic [AW-1:0]     bidx;
    logic [6:0]        dev7;

    // Fold address bits above the programmed length into the device address.
    always_comb begin
        hi_bits = addr >> {alen, 3'b000};
        dev7    = fold_en ? (chip | (hi_bits[6:0] & mask)) : chip;
        dev_wr  = {dev7, 1'b0};
        dev_rd  = {dev7, 1'b1};
    end

    // Pick the internal address byte, most significant first.
    always_comb begin
        bidx      = aidx - 1'b1;
        sel_bits  = addr >> {bidx, 3'b000};
        addr_byte = sel_bits[7:0];
    end

endmodule

// File: rtl/i2c_xact_ctrl.sv
// Transaction control: walks the primitive sequence of a probe, read or
// write, issues one engine primitive at a time, and gathers status.
// Assumes: the engine answers each eng_req pulse with exactly one eng_done.
module i2c_xact_ctrl
    import i2c_xact_pkg::*;
#(
    parameter int ABYTES = 4,
    parameter int LEN_W  = 8,
    localparam int AW    = $clog2(ABYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_alen,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cfg_rep_start,
    input  logic [7:0]       dev_wr,
    input  logic [7:0]       dev_rd,
    input  logic [7:0]       addr_byte,
    output logic             accept,
    output logic [AW-1:0]    alen_q,
    output logic [AW-1:0]    aidx_q,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             eng_req,
    output logic [1:0]       eng_op,
    output logic [7:0]       eng_wdata,
    output logic             eng_nack_out,
    input  logic             eng_done,
    input  logic             eng_nack_in,
    input  logic [7:0]       eng_rdata,
    output logic             busy,
    output logic             done,
    output logic             st_present,
    output logic             st_nochip,
    output logic             st_addr_err,
    output logic [LEN_W-1:0] st_fail_cnt
);

    seq_state_e       state_q;
    eng_op_e          op_sel;
    logic [1:0]       op_q;
    logic [LEN_W-1:0] rem_q;
    logic             rep_q;
    logic             waiting_q;
    logic             active;
    logic             complete;
    logic             is_probe;
    logic             is_read;
    logic             last_byte;

    assign is_probe  = (op_q == OP_PROBE);
    assign is_read   = (op_q == OP_READ);
    assign last_byte = (rem_q == LEN_W'(1));
    assign complete  = waiting_q && eng_done;
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_FIN);
    assign accept    = cmd_valid && (state_q == S_IDLE);

    // Primitive selection and request issue for the current state.
    always_comb begin
        active   = (state_q != S_IDLE) && (state_q != S_FIN);
        wr_ready = (state_q == S_WDATA) && !waiting_q;
        eng_req  = active && !waiting_q && !((state_q == S_WDATA) && !wr_valid);
        case (state_q)
            S_START, S_MSTART: op_sel = ENG_START;
            S_MSTOP, S_STOP:   op_sel = ENG_STOP;
            S_RDATA:           op_sel = ENG_READ;
            default:           op_sel = ENG_WRITE;
        endcase
        case (state_q)
            S_DEVW:  eng_wdata = dev_wr;
            S_ADDR:  eng_wdata = addr_byte;
            S_DEVR:  eng_wdata = dev_rd;
            S_WDATA: eng_wdata = wr_data;
            default: eng_wdata = 8'h00;
        endcase
        eng_nack_out = (state_q == S_RDATA) && last_byte;
    end

    assign eng_op = op_sel;

    // Sequence state, counters, read strobe and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            op_q        <= 2'd0;
            alen_q      <= '0;
            aidx_q      <= '0;
            rem_q       <= '0;
            rep_q       <= 1'b0;
            waiting_q   <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= 8'h00;
            st_present  <= 1'b0;
            st_nochip   <= 1'b0;
            st_addr_err <= 1'b0;
            st_fail_cnt <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (eng_req) begin
                waiting_q <= 1'b1;
            end
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q        <= cmd_op;
                        alen_q      <= cmd_alen;
                        aidx_q      <= cmd_alen;
                        rem_q       <= cmd_len;
                        rep_q       <= cfg_rep_start;
                        st_present  <= 1'b0;
                        st_nochip   <= 1'b0;
                        st_addr_err <= 1'b0;
                        st_fail_cnt <= '0;
                        state_q     <= S_START;
                    end
                end
                S_FIN: state_q <= S_IDLE;
                default: begin
                    if (complete) begin
                        waiting_q <= 1'b0;
                        case (state_q)
                            S_START: begin
                                state_q <= (is_read && alen_q == '0) ? S_DEVR : S_DEVW;
                            end
                            S_DEVW: begin
                                if (is_probe) begin
                                    st_present <= !eng_nack_in;
                                    state_q    <= S_STOP;
                                end else if (eng_nack_in) begin
                                    st_nochip <= 1'b1;
                                    state_q   <= S_STOP;
                                end else if (alen_q != '0) begin
                                    state_q <= S_ADDR;
                                end else begin
                                    state_q <= (rem_q != '0) ? S_WDATA : S_STOP;
                                end
                            end
                            S_ADDR: begin
                                if (eng_nack_in) begin
                                    st_addr_err <= 1'b1;
                                    state_q     <= S_FIN;
                                end else if (aidx_q == AW'(1)) begin
                                    if (is_read) begin
                                        state_q <= rep_q ? S_MSTART : S_MSTOP;
                                    end else begin
                                        state_q <= (rem_q != '0) ? S_WDATA : S_STOP;
                                    end
                                end else begin
                                    aidx_q <= aidx_q - 1'b1;
                                end
                            end
                            S_MSTOP:  state_q <= S_MSTART;
                            S_MSTART: state_q <= S_DEVR;
                            S_DEVR:   state_q <= (rem_q != '0) ? S_RDATA : S_STOP;
                            S_RDATA: begin
                                rd_valid <= 1'b1;
                                rd_data  <= eng_rdata;
                                rem_q    <= rem_q - 1'b1;
                                if (last_byte) begin
                                    state_q <= S_STOP;
                                end
                            end
                            S_WDATA: begin
                                if (eng_nack_in) begin
                                    st_fail_cnt <= st_fail_cnt + 1'b1;
                                end
                                rem_q <= rem_q - 1'b1;
                                if (last_byte) begin
                                    state_q <= S_STOP;
                                end
                            end
                            S_STOP:  state_q <= S_FIN;
                            default: state_q <= S_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_xact_seq.sv
// Top of the I2C transaction sequencer: latches the command addressing
// fields, builds address bytes and runs the control sequence.
// Assumes: commands are offered only while busy is low; cmd_alen <= ABYTES.
module i2c_xact_seq #(
    parameter int ABYTES = 4,
    parameter int LEN_W  = 8,
    localparam int AW     = $clog2(ABYTES + 1),
    localparam int ADDR_W = 8 * ABYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [6:0]        cmd_chip,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [AW-1:0]     cmd_alen,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cfg_rep_start,
    input  logic [6:0]        cfg_fold_mask,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_wdata,
    output logic              eng_nack_out,
    input  logic              eng_done,
    input  logic              eng_nack_in,
    input  logic [7:0]        eng_rdata,
    output logic              busy,
    output logic              done,
    output logic              st_present,
    output logic              st_nochip,
    output logic              st_addr_err,
    output logic [LEN_W-1:0]  st_fail_cnt
);

    logic              accept;
    logic [6:0]        chip_q;
    logic [ADDR_W-1:0] addr_q;
    logic [6:0]        mask_q;
    logic              fold_q;
    logic [AW-1:0]     alen_q;
    logic [AW-1:0]     aidx_q;
    logic [7:0]        dev_wr;
    logic [7:0]        dev_rd;
    logic [7:0]        addr_byte;

    // Hold the addressing fields of the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_q <= '0;
            addr_q <= '0;
            mask_q <= '0;
            fold_q <= 1'b0;
        end else if (accept) begin
            chip_q <= cmd_chip;
            addr_q <= cmd_addr;
            mask_q <= cfg_fold_mask;
            fold_q <= (cmd_op != i2c_xact_pkg::OP_PROBE);
        end
    end

    i2c_xact_addr #(.ABYTES(ABYTES)) u_addr (
        .chip      (chip_q),
        .addr      (addr_q),
        .alen      (alen_q),
        .aidx      (aidx_q),
        .mask      (mask_q),
        .fold_en   (fold_q),
        .dev_wr    (dev_wr),
        .dev_rd    (dev_rd),
        .addr_byte (addr_byte)
    );

    i2c_xact_ctrl #(.ABYTES(ABYTES), .LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_alen      (cmd_alen),
        .cmd_len       (cmd_len),
        .cfg_rep_start (cfg_rep_start),
        .dev_wr        (dev_wr),
        .dev_rd        (dev_rd),
        .addr_byte     (addr_byte),
        .accept        (accept),
        .alen_q        (alen_q),
        .aidx_q        (aidx_q),
        .wr_data       (wr_data),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .eng_req       (eng_req),
        .eng_op        (eng_op),
        .eng_wdata     (eng_wdata),
        .eng_nack_out  (eng_nack_out),
        .eng_done      (eng_done),
        .eng_nack_in   (eng_nack_in),
        .eng_rdata     (eng_rdata),
        .busy          (busy),
        .done          (done),
        .st_present    (st_present),
        .st_nochip     (st_nochip),
        .st_addr_err   (st_addr_err),
        .st_fail_cnt   (st_fail_cnt)
    );

endmodule

// File: rtl/i2c_xact_chk.sv
// Protocol checker for the I2C transaction sequencer, bound to its top.
// Assumes: synchronous active-low reset on rst_n.
module i2c_xact_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic             done,
    input logic             eng_req,
    input logic             eng_done,
    input logic [1:0]       eng_op,
    input logic [7:0]       eng_wdata,
    input logic [7:0]       wr_data,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic [LEN_W-1:0] st_fail_cnt,
    input logic             st_nochip,
    input logic             st_addr_err,
    input logic             st_present
);

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R12
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    // R7
    rd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(eng_done));

    // R11
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy && !done);

    // R9
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |-> (eng_req && eng_op == 2'd2 && eng_wdata == wr_data));

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(st_fail_cnt) && $stable(st_nochip)
                                   && $stable(st_addr_err) && $stable(st_present)));

endmodule

bind i2c_xact_seq i2c_xact_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;

    localparam int ABYTES = 4;
    localparam int LEN_W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [6:0]  cmd_chip = '0;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_alen = '0;
    logic [7:0]  cmd_len = '0;
    logic        cfg_rep_start = 1'b0;
    logic [6:0]  cfg_fold_mask = '0;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic [7:0]  eng_wdata;
    logic        eng_nack_out;
    logic        eng_done = 1'b0;
    logic        eng_nack_in = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic        busy, done, st_present, st_nochip, st_addr_err;
    logic [7:0]  st_fail_cnt;

    int nchk = 0;
    int nfail = 0;
    logic [10:0] q[$];
    logic [7:0]  rq[$];
    logic [31:0] nack_mask = '0;
    int   wk = 0;
    int   rk = 0;
    logic [7:0] wcnt = '0;
    bit   prev_take = 0;
    bit   pend = 0;
    int   dly = 0;
    bit   resp_nack = 0;
    logic [7:0] resp_data = '0;
    string cur_tag = "R12";

    assign wr_data = 8'hC0 + wcnt;

    always #5 clk = ~clk;

    i2c_xact_seq #(.ABYTES(ABYTES), .LEN_W(LEN_W)) dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void push(input int op, input int data, input int flag);
        q.push_back({op[1:0], data[7:0], flag[0]});
    endfunction

    // Byte-engine model and scoreboard monitor: compares each primitive
    // against the expected queue and answers after a short delay.
    always @(negedge clk) begin
        if (prev_take) wcnt = wcnt + 8'd1;
        prev_take = wr_valid && wr_ready;
        eng_done = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                eng_done    = 1'b1;
                eng_nack_in = resp_nack;
                eng_rdata   = resp_data;
                pend        = 0;
            end else begin
                dly--;
            end
        end else if (eng_req) begin
            logic [10:0] it;
            if (q.size() == 0) begin
                chk(0, cur_tag, "unexpected primitive", eng_op, 4);
            end else begin
                it = q.pop_front();
                chk(eng_op == it[10:9], cur_tag, "primitive op", eng_op, it[10:9]);
                if (it[10:9] == 2'd2)
                    chk(eng_wdata == it[8:1], cur_tag, "written byte", eng_wdata, it[8:1]);
                if (it[10:9] == 2'd3)
                    chk(eng_nack_out == it[0], cur_tag, "read ack level", eng_nack_out, it[0]);
            end
            resp_nack = 0;
            resp_data = 8'h00;
            if (eng_op == 2'd2) begin
                resp_nack = nack_mask[wk];
                wk++;
            end
            if (eng_op == 2'd3) begin
                resp_data = 8'h30 + rk[7:0];
                rk++;
            end
            pend = 1;
            dly  = 1;
        end
    end

    // Read stream monitor.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (rq.size() == 0) begin
                chk(0, "R7", "unexpected read byte", rd_data, 0);
            end else begin
                logic [7:0] e;
                e = rq.pop_front();
                chk(rd_data == e, "R7", "read byte", rd_data, e);
            end
        end
    end

    // Driver: builds the expected primitive stream from the requirements,
    // issues the command and checks the final status.
    task automatic run(input string tag, input int op, input int chip, input longint addr,
                       input int alen, input int len, input bit rep, input int mask,
                       input logic [31:0] nm);
        int wi = 0;
        int eff;
        bit present = 0, nochip = 0, aerr = 0, ended = 0;
        int fail = 0;
        @(posedge clk);
        q.delete();
        rq.delete();
        nack_mask = nm;
        wk = 0;
        rk = 0;
        wcnt = '0;
        cur_tag = tag;
        eff = (op == 0) ? chip : ((chip | int'((addr >> (alen * 8)) & longint'(mask))) & 'h7f);
        push(0, 0, 0);
        if (op == 0) begin
            push(2, eff << 1, 0);
            present = !nm[wi];
            push(1, 0, 0);
        end else begin
            if (op == 2 || alen > 0) begin
                push(2, eff << 1, 0);
                if (nm[wi]) begin
                    nochip = 1;
                    push(1, 0, 0);
                    ended = 1;
                end
                wi++;
                for (int a = alen - 1; a >= 0 && !ended; a--) begin
                    push(2, int'((addr >> (8 * a)) & 'hff), 0);
                    if (nm[wi]) begin
                        aerr = 1;
                        ended = 1;
                    end
                    wi++;
                end
            end
            if (!ended) begin
                if (op == 1) begin
                    if (alen > 0) begin
                        if (!rep) push(1, 0, 0);
                        push(0, 0, 0);
                    end
                    push(2, (eff << 1) | 1, 0);
                    wi++;
                    for (int i = 0; i < len; i++) begin
                        push(3, 0, (i == len - 1) ? 1 : 0);
                        rq.push_back(8'h30 + i[7:0]);
                    end
                    push(1, 0, 0);
                end else begin
                    for (int i = 0; i < len; i++) begin
                        push(2, 'hC0 + i, 0);
                        if (nm[wi]) fail++;
                        wi++;
                    end
                    push(1, 0, 0);
                end
            end
        end
        @(negedge clk);
        cmd_op        = op[1:0];
        cmd_chip      = chip[6:0];
        cmd_addr      = addr[31:0];
        cmd_alen      = alen[2:0];
        cmd_len       = len[7:0];
        cfg_rep_start = rep;
        cfg_fold_mask = mask[6:0];
        cmd_valid     = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && !st_present && !st_nochip && !st_addr_err && st_fail_cnt == 0,
            "R11", "status cleared on accept", {busy, st_present, st_nochip, st_addr_err}, 8);
        do @(negedge clk); while (!done);
        chk(q.size() == 0, tag, "primitives left unsent", q.size(), 0);
        chk(rq.size() == 0, tag, "read bytes missing", rq.size(), 0);
        chk(st_present == present, tag, "st_present", st_present, present);
        chk(st_nochip == nochip, tag, "st_nochip", st_nochip, nochip);
        chk(st_addr_err == aerr, tag, "st_addr_err", st_addr_err, aerr);
        chk(st_fail_cnt == fail[7:0], tag, "st_fail_cnt", st_fail_cnt, fail);
        @(negedge clk);
        chk(!busy && !done, "R11", "done is one cycle", {busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!busy && !done && !eng_req && !rd_valid && !wr_ready, "R12", "reset outputs",
            {busy, done, eng_req, rd_valid, wr_ready}, 0);
        chk(!st_present && !st_nochip && !st_addr_err && st_fail_cnt == 0, "R11",
            "reset status", {st_present, st_nochip, st_addr_err}, 0);

        run("R1", 0, 'h50, 0, 0, 0, 0, 0, 32'h0);          // probe, present
        run("R1", 0, 'h23, 'h3FF, 2, 0, 0, 'h7f, 32'h1);   // probe, absent, no folding
        run("R3", 1, 'h50, 'h1234, 2, 3, 0, 0, 32'h0);     // R5 STOP then START
        run("R5", 1, 'h50, 'h1234, 2, 1, 1, 0, 32'h0);     // repeated START
        run("R6", 1, 'h3A, 'h55, 0, 2, 0, 0, 32'h1);       // R7 read-address NACK ignored
        run("R2", 1, 'h11, 'hABCD, 2, 2, 0, 0, 32'h1);     // read, no chip
        run("R4", 1, 'h50, 'h1234, 2, 2, 0, 0, 32'h4);     // second address byte NACK
        run("R9", 2, 'h51, 'h07, 1, 3, 0, 0, 32'h8);       // one data NACK
        repeat (6) @(negedge clk);
        chk(st_fail_cnt == 8'd1, "R11", "status held while idle", st_fail_cnt, 1);
        run("R9", 2, 'h51, 'h0123, 3, 3, 0, 0, 32'h70);    // all data NACK
        run("R10", 2, 'h52, 'h0102, 2, 0, 0, 0, 32'h0);    // zero-length write
        run("R10", 1, 'h52, 'h09, 1, 0, 0, 0, 32'h0);      // zero-length read
        run("R8", 1, 'h50, 'h2AB, 1, 1, 1, 'h03, 32'h0);   // folded read
        run("R8", 2, 'h50, 'h51234, 2, 2, 0, 'h07, 32'h0); // folded write
        run("R2", 2, 'h60, 'h10, 1, 2, 0, 0, 32'h1);       // write, no chip
        run("R4", 2, 'h60, 'h10, 1, 2, 0, 0, 32'h2);       // write address NACK
        run("R7", 1, 'h44, 'h01020304, 4, 5, 1, 0, 32'h0); // long read, 4 address bytes

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R12 watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule